// File: doc/BRIEF.md
# Float-to-integer invalid result selector

This block is the last stage of a floating-point to integer conversion. An upstream classifier and rounder hand it the operand's NaN and infinity flags and the already rounded value as a sign bit, a 64-bit magnitude and a "huge" flag. The huge flag marks a magnitude of 2^64 or more. The block also receives the target width, which is 32 or 64 bits. It decides whether the conversion is in range. It then registers either the two's-complement integer or a saturation code for the destination, and it records the overflow and invalid conditions in sticky bits of a 32-bit control/status register.

The block also owns that control/status register. A core-variant parameter selects the NaN-mode behaviour. The newer variant resets with the NaN-mode bit set and keeps it set through every software write. The older variant keeps the bit clear. With NaN mode on, a NaN converts to zero and the two overflow directions give different codes. With NaN mode off, every invalid conversion gives the positive code.

Top module: `cvt_sat_unit`

## Requirements
- R1: After reset the status register reads 0x0004_0000 (NaN-mode bit 18 set) when NEWER_VARIANT=1, and 0x0000_0000 when NEWER_VARIANT=0.
- R2: A write (`csr_we`) stores `csr_wdata` into the status register, except that bit 18 is forced to 1 for NEWER_VARIANT=1 and to 0 for NEWER_VARIANT=0.
- R3: A request on `in_valid` gives `out_valid` high exactly one cycle later, and `out_valid` is low otherwise. An in-range result is the signed value (sign applied to the magnitude). A 32-bit result is sign-extended to 64 bits. An in-range result leaves the status register unchanged.
- R4: With NaN mode on, a NaN operand gives a result of 0.
- R5: With NaN mode on, positive overflow gives the positive code and negative overflow gives the negative code. For a 32-bit target the codes are 0x0000_0000_7FFF_FFFF and 0xFFFF_FFFF_8000_0000. For a 64-bit target they are 0x7FFF_FFFF_FFFF_FFFF and 0x8000_0000_0000_0000.
- R6: With NaN mode off, every invalid conversion (NaN, or out of range in either direction) gives the positive code of the target width.
- R7: For a 64-bit target, any value of 2^63 or more is positive overflow, and any value below -2^63 is negative overflow. For a 32-bit target, any value above 2^31-1 is positive overflow, and any value below -2^31 is negative overflow. A huge magnitude, or an infinite operand, overflows on the side of its sign.
- R8: An out-of-range conversion sets both the overflow bit (bit 2) and the invalid bit (bit 4). A NaN sets only the invalid bit. Both bits stay set until software writes the register.
- R9: When a software write and a conversion fall in the same cycle, the written value wins and the conversion's flags are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Conversion request |
| in_wide | input | 1 | 1 = 64-bit target, 0 = 32-bit target |
| src_nan | input | 1 | Operand is NaN |
| src_inf | input | 1 | Operand is infinite |
| rnd_sign | input | 1 | Sign of the rounded value |
| rnd_huge | input | 1 | Rounded magnitude is 2^64 or more |
| rnd_mag | input | 64 | Rounded magnitude |
| csr_we | input | 1 | Status register write strobe |
| csr_wdata | input | 32 | Status register write data |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_data | output | 64 | Destination integer |
| csr_rd | output | 32 | Current status register value |

## Verification
The corner that is hardest to reach is the exact edge of each range. The inclusive 2^63 limit sits next to the exclusive -2^63 limit, and both differ from the 32-bit limits, so an off-by-one fault is easy to miss. The bench sweeps the magnitudes on either side of 2^31 and 2^63 for both signs and both widths. It applies the same stimulus to one instance of each variant. Before each conversion it clears the status register, so that the flags from that single conversion can be read back.

// File: rtl/cvt_sat_pkg.sv
package cvt_sat_pkg;
  localparam int DW    = 64;
  localparam int HW    = 32;
  localparam int CSR_W = 32;

  typedef struct packed {
    logic pos;
    logic neg;
  } ovf_t;

  // smallest positive magnitude that no longer fits the target
  function automatic logic [DW-1:0] pos_limit(input logic wide);
    logic [DW-1:0] one;
    one = {{(DW-1){1'b0}}, 1'b1};
    return wide ? (one << (DW-1)) : (one << (HW-1));
  endfunction

  // Range test on sign-magnitude: positive fails at mag >= limit,
  // negative fails only above it (the negative end is one wider).
  function automatic ovf_t classify(input logic sgn, input logic huge,
                                    input logic [DW-1:0] mag, input logic wide);
    ovf_t r;
    logic [DW-1:0] lim;
    lim   = pos_limit(wide);
    r.pos = !sgn && (huge || (mag >= lim));
    r.neg = sgn && (huge || (mag > lim));
    return r;
  endfunction

  function automatic logic [DW-1:0] to_twos(input logic sgn, input logic [DW-1:0] mag,
                                            input logic wide);
    logic [DW-1:0] t;
    t = sgn ? (~mag + {{(DW-1){1'b0}}, 1'b1}) : mag;
    if (!wide) t = {{(DW-HW){t[HW-1]}}, t[HW-1:0]};
    return t;
  endfunction

  function automatic logic [DW-1:0] pos_code(input logic wide);
    return wide ? {1'b0, {(DW-1){1'b1}}} : {{(DW-HW+1){1'b0}}, {(HW-1){1'b1}}};
  endfunction

  function automatic logic [DW-1:0] neg_code(input logic wide);
    return wide ? {1'b1, {(DW-1){1'b0}}} : {{(DW-HW+1){1'b1}}, {(HW-1){1'b0}}};
  endfunction
endpackage

// File: rtl/cvt_sat_range.sv
module cvt_sat_range
  import cvt_sat_pkg::*;
(
  input  logic          in_wide,
  input  logic          src_nan,
  input  logic          src_inf,
  input  logic          rnd_sign,
  input  logic          rnd_huge,
  input  logic [DW-1:0] rnd_mag,
  output logic          ovf_pos,
  output logic          ovf_neg,
  output logic          nan_hit,
  output logic          oor_hit
);
  ovf_t cls;

  always_comb begin
    cls     = classify(rnd_sign, rnd_huge | src_inf, rnd_mag, in_wide);
    nan_hit = src_nan;
    ovf_pos = !src_nan && cls.pos;
    ovf_neg = !src_nan && cls.neg;
    oor_hit = ovf_pos | ovf_neg;
  end
endmodule

// File: rtl/cvt_sat_select.sv
module cvt_sat_select
  import cvt_sat_pkg::*;
(
  input  logic          mode_nan,
  input  logic          in_wide,
  input  logic          nan_hit,
  input  logic          ovf_pos,
  input  logic          ovf_neg,
  input  logic          rnd_sign,
  input  logic [DW-1:0] rnd_mag,
  output logic [DW-1:0] dst
);
  always_comb begin
    if (!(nan_hit || ovf_pos || ovf_neg)) dst = to_twos(rnd_sign, rnd_mag, in_wide);
    else if (!mode_nan)                   dst = pos_code(in_wide);
    else if (nan_hit)                     dst = '0;
    else if (ovf_pos)                     dst = pos_code(in_wide);
    else                                  dst = neg_code(in_wide);
  end
endmodule

// File: rtl/cvt_sat_status.sv
module cvt_sat_status
  import cvt_sat_pkg::*;
#(
  parameter int NEWER_VARIANT = 1,
  parameter int NAN_BIT       = 18,
  parameter int OVF_BIT       = 2,
  parameter int INV_BIT       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  input  logic             set_ovf,
  input  logic             set_inv,
  output logic [CSR_W-1:0] csr_q
);
  localparam logic [CSR_W-1:0] NAN_MASK = CSR_W'(1) << NAN_BIT;
  localparam logic [CSR_W-1:0] OVF_MASK = CSR_W'(1) << OVF_BIT;
  localparam logic [CSR_W-1:0] INV_MASK = CSR_W'(1) << INV_BIT;
  localparam logic [CSR_W-1:0] RST_VAL  = (NEWER_VARIANT != 0) ? NAN_MASK : '0;

  logic [CSR_W-1:0] wr_val;
  logic [CSR_W-1:0] flag_set;

  generate
    if (NEWER_VARIANT != 0) begin : g_nan_on
      assign wr_val = wr_data | NAN_MASK;
    end else begin : g_nan_off
      assign wr_val = wr_data & ~NAN_MASK;
    end
  endgenerate

  assign flag_set = (set_ovf ? OVF_MASK : '0) | (set_inv ? INV_MASK : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     csr_q <= RST_VAL;
    else if (wr_en) csr_q <= wr_val;
    else            csr_q <= csr_q | flag_set;
  end
endmodule

// File: rtl/cvt_sat_unit.sv
module cvt_sat_unit
  import cvt_sat_pkg::*;
#(
  parameter int NEWER_VARIANT = 1,
  parameter int NAN_BIT       = 18,
  parameter int OVF_BIT       = 2,
  parameter int INV_BIT       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_wide,
  input  logic             src_nan,
  input  logic             src_inf,
  input  logic             rnd_sign,
  input  logic             rnd_huge,
  input  logic [DW-1:0]    rnd_mag,
  input  logic             csr_we,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic [CSR_W-1:0] csr_rd
);
  logic          ovf_pos, ovf_neg, nan_hit, oor_hit;
  logic          mode_bit;
  logic [DW-1:0] dst_d;
  logic          set_ovf, set_inv;

  cvt_sat_range u_range (
    .in_wide (in_wide),  .src_nan (src_nan),  .src_inf (src_inf),
    .rnd_sign(rnd_sign), .rnd_huge(rnd_huge), .rnd_mag (rnd_mag),
    .ovf_pos (ovf_pos),  .ovf_neg (ovf_neg),  .nan_hit (nan_hit),
    .oor_hit (oor_hit)
  );

  assign mode_bit = csr_rd[NAN_BIT];

  cvt_sat_select u_select (
    .mode_nan(mode_bit), .in_wide (in_wide),  .nan_hit(nan_hit),
    .ovf_pos (ovf_pos),  .ovf_neg (ovf_neg),  .rnd_sign(rnd_sign),
    .rnd_mag (rnd_mag),  .dst     (dst_d)
  );

  assign set_ovf = in_valid && oor_hit;
  assign set_inv = in_valid && (oor_hit || nan_hit);

  cvt_sat_status #(
    .NEWER_VARIANT(NEWER_VARIANT), .NAN_BIT(NAN_BIT),
    .OVF_BIT(OVF_BIT), .INV_BIT(INV_BIT)
  ) u_status (
    .clk(clk), .rst_n(rst_n), .wr_en(csr_we), .wr_data(csr_wdata),
    .set_ovf(set_ovf), .set_inv(set_inv), .csr_q(csr_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= dst_d;
    end
  end
endmodule

// File: rtl/cvt_sat_chk.sv
module cvt_sat_chk
  import cvt_sat_pkg::*;
#(
  parameter int NEWER_VARIANT = 1,
  parameter int NAN_BIT       = 18,
  parameter int OVF_BIT       = 2,
  parameter int INV_BIT       = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             csr_we,
  input logic [CSR_W-1:0] csr_wdata,
  input logic             oor_hit,
  input logic             nan_hit,
  input logic             mode_bit,
  input logic             out_valid,
  input logic [DW-1:0]    out_data,
  input logic [CSR_W-1:0] csr_rd
);
  localparam logic MODE_EXP = (NEWER_VARIANT != 0);

  // R3
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R3
  idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3
  quiet_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !oor_hit && !nan_hit && !csr_we) |=> (csr_rd == $past(csr_rd)));
  // R2
  mode_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd[NAN_BIT] == MODE_EXP);
  // R4
  nan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nan_hit && mode_bit) |=> (out_data == '0));
  // R6
  legacy_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (nan_hit || oor_hit) && !mode_bit) |=>
      (!out_data[DW-1] && (out_data[HW-2:0] == {(HW-1){1'b1}})));
  // R8
  both_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && oor_hit && !csr_we) |=> (csr_rd[OVF_BIT] && csr_rd[INV_BIT]));
  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |=> (csr_rd[OVF_BIT] == $past(csr_wdata[OVF_BIT])));
endmodule

bind cvt_sat_unit cvt_sat_chk #(
  .NEWER_VARIANT(NEWER_VARIANT), .NAN_BIT(NAN_BIT),
  .OVF_BIT(OVF_BIT), .INV_BIT(INV_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .csr_we(csr_we),
  .csr_wdata(csr_wdata), .oor_hit(oor_hit), .nan_hit(nan_hit),
  .mode_bit(mode_bit), .out_valid(out_valid), .out_data(out_data),
  .csr_rd(csr_rd)
);

// File: tb/test_cvt_sat_unit.sv
`timescale 1ns/1ps
module test_cvt_sat_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_wide = 1'b0, src_nan = 1'b0, src_inf = 1'b0;
  logic        rnd_sign = 1'b0, rnd_huge = 1'b0;
  logic [63:0] rnd_mag = '0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic        ov_n, ov_o;
  logic [63:0] od_n, od_o;
  logic [31:0] cs_n, cs_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cvt_sat_unit #(.NEWER_VARIANT(1)) i_cvt_sat_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wide(in_wide),
    .src_nan(src_nan), .src_inf(src_inf), .rnd_sign(rnd_sign), .rnd_huge(rnd_huge),
    .rnd_mag(rnd_mag), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .out_valid(ov_n), .out_data(od_n), .csr_rd(cs_n));

  cvt_sat_unit #(.NEWER_VARIANT(0)) i_cvt_sat_unit_legacy (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wide(in_wide),
    .src_nan(src_nan), .src_inf(src_inf), .rnd_sign(rnd_sign), .rnd_huge(rnd_huge),
    .rnd_mag(rnd_mag), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .out_valid(ov_o), .out_data(od_o), .csr_rd(cs_o));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [31:0] d);
    @(negedge clk); csr_we = 1'b1; csr_wdata = d;
    @(negedge clk); csr_we = 1'b0;
  endtask

  // expected result computed as signed arithmetic against integer limits
  task automatic model(input bit newv, input bit wide, input bit nan, input bit inf,
                       input bit sgn, input bit huge, input logic [63:0] mag,
                       output logic [63:0] data, output bit ovf, output bit inv);
    logic signed [67:0] v;
    bit hi, lo;
    logic [63:0] pc, nc;
    v  = $signed({4'b0, mag});
    if (sgn) v = -v;
    pc = wide ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
    nc = wide ? 64'h8000_0000_0000_0000 : 64'hFFFF_FFFF_8000_0000;
    if (huge || inf) begin hi = !sgn; lo = sgn; end
    else if (wide) begin
      hi = v >= 68'sh0_8000_0000_0000_0000;
      lo = v < -68'sh0_8000_0000_0000_0000;
    end else begin
      hi = v > 68'sd2147483647;
      lo = v < -68'sd2147483648;
    end
    ovf = 0; inv = 0;
    if (nan) begin inv = 1; data = newv ? 64'd0 : pc; end
    else if (hi || lo) begin
      ovf = 1; inv = 1;
      data = (!newv || hi) ? pc : nc;
    end else data = v[63:0];
  endtask

  task automatic run_one(input string req, input bit wide, input bit nan, input bit inf,
                         input bit sgn, input bit huge, input logic [63:0] mag);
    logic [63:0] dn, dl;
    bit fo_n, fi_n, fo_l, fi_l;
    csr_write(32'h0);
    @(negedge clk);
    in_valid = 1; in_wide = wide; src_nan = nan; src_inf = inf;
    rnd_sign = sgn; rnd_huge = huge; rnd_mag = mag;
    @(negedge clk);
    in_valid = 0;
    model(1, wide, nan, inf, sgn, huge, mag, dn, fo_n, fi_n);
    model(0, wide, nan, inf, sgn, huge, mag, dl, fo_l, fi_l);
    chk({req, " R3 valid"}, {63'd0, ov_n & ov_o}, 64'd1);
    chk({req, " data nan-mode"}, od_n, dn);
    chk({req, " data legacy"}, od_o, dl);
    chk({req, " R8 flags nan-mode"}, {32'd0, cs_n},
        {32'd0, 32'h0004_0000 | (fo_n ? 32'h4 : 0) | (fi_n ? 32'h10 : 0)});
    chk({req, " R8 flags legacy"}, {32'd0, cs_o},
        {32'd0, (fo_l ? 32'h4 : 32'h0) | (fi_l ? 32'h10 : 32'h0)});
  endtask

  function automatic logic [63:0] mag_pick(input int k);
    case (k)
      0: return 64'd0;
      1: return 64'd1;
      2: return 64'h0000_0000_7FFF_FFFF;
      3: return 64'h0000_0000_8000_0000;
      4: return 64'h0000_0000_8000_0001;
      5: return 64'h7FFF_FFFF_FFFF_FFFF;
      6: return 64'h8000_0000_0000_0000;
      7: return 64'h8000_0000_0000_0001;
      8: return 64'hFFFF_FFFF_FFFF_FFFF;
      default: return 64'h0000_0000_1234_5678;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 reset nan-mode", {32'd0, cs_n}, 64'h0004_0000);
    chk("R1 reset legacy", {32'd0, cs_o}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 idle out_valid", {63'd0, ov_n | ov_o}, 64'd0);
    // R2 write forcing
    csr_write(32'hFFFF_FFFF);
    chk("R2 write nan-mode", {32'd0, cs_n}, 64'hFFFF_FFFF);
    chk("R2 write legacy", {32'd0, cs_o}, 64'hFFFB_FFFF);
    csr_write(32'h0000_0A00);
    chk("R2 write nan-mode b", {32'd0, cs_n}, 64'h0004_0A00);
    chk("R2 write legacy b", {32'd0, cs_o}, 64'h0000_0A00);
    // R3 R5 R6 R7 sweep of boundaries
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 10; k++)
          run_one("R7 R5 R6 sweep", w[0], 0, 0, s[0], 0, mag_pick(k));
    // R4 R6 NaN, R7 huge and infinity
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 2; s++) begin
        run_one("R4 nan", w[0], 1, 0, s[0], 0, 64'd5);
        run_one("R7 huge", w[0], 0, 0, s[0], 1, 64'd3);
        run_one("R7 inf", w[0], 0, 1, s[0], 0, 64'd0);
      end
    // R8 stickiness, and R3 in-range keeps flags untouched
    csr_write(32'h0);
    @(negedge clk);
    in_valid = 1; in_wide = 0; src_nan = 0; src_inf = 0; rnd_sign = 1; rnd_huge = 0;
    rnd_mag = 64'h1_0000_0000;
    @(negedge clk);
    rnd_sign = 0; rnd_mag = 64'd77;
    @(negedge clk);
    in_valid = 0;
    chk("R3 in-range after overflow data", od_n, 64'd77);
    chk("R8 sticky nan-mode", {32'd0, cs_n}, 64'h0004_0014);
    chk("R8 sticky legacy", {32'd0, cs_o}, 64'h14);
    // R9 write in the same cycle as an overflowing conversion
    @(negedge clk);
    in_valid = 1; in_wide = 1; rnd_sign = 0; rnd_mag = 64'h8000_0000_0000_0000;
    csr_we = 1; csr_wdata = 32'h0000_0100;
    @(negedge clk);
    in_valid = 0; csr_we = 0;
    chk("R9 write wins nan-mode", {32'd0, cs_n}, 64'h0004_0100);
    chk("R9 write wins legacy", {32'd0, cs_o}, 64'h0100);
    chk("R9 result still produced", od_n, 64'h7FFF_FFFF_FFFF_FFFF);
    @(negedge clk);
    chk("R3 out_valid drops", {63'd0, ov_n | ov_o}, 64'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule